// File: doc/BRIEF.md
# Protected Register Unlock Sequencer

This block sits beside a CPU store bus and guards one protected control register. Software cannot write that register with a single store. Each update needs three stores. First comes an arming store of a fixed key to a command address. The second store goes to the protected address and carries the one's complement of the wanted value. The third store goes to the protected address and carries the value itself. Only a sequence that is fully correct changes the register.

Any wrong step ends the attempt and sets a sticky error flag. A wrong step is a store to a different address, or a final value that does not complement the image. Software clears the flag by storing a value with bit 0 low to the flag address. The block drives out the register value, the error flag, and a one-cycle pulse each time an update is accepted. Each store on the bus lasts one cycle, marked by a valid strobe.

Top module: `prot_reg_guard`

## Requirements
- R1: Reset sets the protected value to 8'h00, clears the error flag and holds the update pulse low.
- R2: In the idle state, a store of 8'hA5 to the command address (8'h10) arms the sequencer. A store of any other data to that address arms nothing and leaves the error flag alone.
- R3: Once armed, the next store must go to the protected address (8'h11), and its data becomes the complement image. A store to any other address sets the error flag. This includes the command address and the flag address. The sequencer then returns to idle.
- R4: After the image store, the next store must also go to the protected address. A store elsewhere sets the error flag, leaves the register unchanged and returns to idle.
- R5: The final data must equal the bitwise inverse of the image. On a mismatch the error flag is set, the register keeps its old value and the sequencer returns to idle.
- R6: A correct final store loads its data into the protected register in the cycle after the store. In that same cycle the update pulse is high, and it is high for exactly one cycle.
- R7: In the idle state, a store to the flag address (8'h12) with bit 0 at 0 clears the error flag. With bit 0 at 1 the store leaves the flag unchanged.
- R8: In the idle state, stores to the protected address or to unrelated addresses change neither the register nor the error flag.
- R9: After any success or error the sequencer is idle again, so stores to the protected address need a new arming store before they take effect.
- R10: Cycles with no store do not advance or abort a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | A store is on the bus this cycle |
| st_addr_i | input | 8 | Store address |
| st_data_i | input | 8 | Store data |
| prot_q_o | output | 8 | Protected register value |
| prot_err_o | output | 1 | Sticky protection error flag |
| upd_pulse_o | output | 1 | One-cycle pulse on an accepted update |

## Verification
The stimulus includes clean three-store sequences, both back to back and with idle gaps. This separates correct arming and capture from any dependence on consecutive cycles. Each broken sequence varies a single point: a stray address after arming, a stray address after the image, or a wrong final value. So every error path is exercised on its own, and each one shows that the register keeps its old value. Stores to the protected address with no arming before them, wrong keys, and flag writes with bit 0 at 1 show that idle traffic has no effect. Flag clears and a reset in the middle of the run show how the flag is removed.

// File: rtl/prot_guard_pkg.sv
package prot_guard_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_INV   = 2'd2
  } seq_st_e;

  typedef struct packed {
    logic cmd;
    logic prot;
    logic flag;
  } hit_t;
endpackage

// File: rtl/prot_guard_dec.sv
module prot_guard_dec
  import prot_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 8'h11,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h12,
  parameter logic [DATA_W-1:0] KEY_VAL   = 8'hA5
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output hit_t              hit_o,
  output logic              key_ok_o
);
  always_comb begin
    hit_o.cmd  = valid_i && (addr_i == CMD_ADDR);
    hit_o.prot = valid_i && (addr_i == PROT_ADDR);
    hit_o.flag = valid_i && (addr_i == FLAG_ADDR);
    key_ok_o   = hit_o.cmd && (data_i == KEY_VAL);
  end
endmodule

// File: rtl/prot_guard_fsm.sv
module prot_guard_fsm
  import prot_guard_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  hit_t              hit_i,
  input  logic              key_ok_i,
  output logic              commit_o,
  output logic              viol_o,
  output logic              clr_o
);
  seq_st_e st_q, st_d;
  logic [DATA_W-1:0] img_q, img_d;

  always_comb begin
    st_d     = st_q;
    img_d    = img_q;
    commit_o = 1'b0;
    viol_o   = 1'b0;
    clr_o    = 1'b0;
    if (valid_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (key_ok_i) st_d = ST_ARMED;
          else if (hit_i.flag && !data_i[0]) clr_o = 1'b1;
        end
        ST_ARMED: begin
          if (hit_i.prot) begin
            img_d = data_i;
            st_d  = ST_INV;
          end else begin
            viol_o = 1'b1;
            st_d   = ST_IDLE;
          end
        end
        ST_INV: begin
          if (hit_i.prot && (data_i == ~img_q)) commit_o = 1'b1;
          else viol_o = 1'b1;
          st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      img_q <= '0;
    end else begin
      st_q  <= st_d;
      img_q <= img_d;
    end
  end
endmodule

// File: rtl/prot_guard_regs.sv
module prot_guard_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              commit_i,
  input  logic              viol_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] prot_q_o,
  output logic              err_o,
  output logic              pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q_o <= '0;
      err_o    <= 1'b0;
      pulse_o  <= 1'b0;
    end else begin
      pulse_o <= commit_i;
      if (commit_i) prot_q_o <= data_i;
      if (viol_i) err_o <= 1'b1;
      else if (clr_i) err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/prot_reg_guard.sv
module prot_reg_guard
  import prot_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 8'h11,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h12,
  parameter logic [DATA_W-1:0] KEY_VAL   = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic [DATA_W-1:0] prot_q_o,
  output logic              prot_err_o,
  output logic              upd_pulse_o
);
  hit_t hit;
  logic key_ok, commit, viol, clr;

  prot_guard_dec #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR),
    .PROT_ADDR(PROT_ADDR), .FLAG_ADDR(FLAG_ADDR), .KEY_VAL(KEY_VAL)
  ) u_dec (
    .valid_i (st_valid_i),
    .addr_i  (st_addr_i),
    .data_i  (st_data_i),
    .hit_o   (hit),
    .key_ok_o(key_ok)
  );

  prot_guard_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (st_valid_i),
    .data_i  (st_data_i),
    .hit_i   (hit),
    .key_ok_i(key_ok),
    .commit_o(commit),
    .viol_o  (viol),
    .clr_o   (clr)
  );

  prot_guard_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (st_data_i),
    .commit_i(commit),
    .viol_i  (viol),
    .clr_i   (clr),
    .prot_q_o(prot_q_o),
    .err_o   (prot_err_o),
    .pulse_o (upd_pulse_o)
  );
endmodule

// File: rtl/prot_reg_guard_chk.sv
module prot_reg_guard_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 8'h11,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              st_valid_i,
  input logic [ADDR_W-1:0] st_addr_i,
  input logic [DATA_W-1:0] st_data_i,
  input logic [DATA_W-1:0] prot_q_o,
  input logic              prot_err_o,
  input logic              upd_pulse_o
);
  // R6: single-cycle pulse
  a_r6_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_pulse_o |=> !upd_pulse_o);

  // R6 / R8: register moves only together with the pulse
  a_r8_q_moves_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prot_q_o) |-> upd_pulse_o);

  // R6: accepted update follows a store to the protected address
  a_r6_pulse_after_prot_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_pulse_o |-> $past(st_valid_i && st_addr_i == PROT_ADDR));

  // R5: success never coincides with an error change
  a_r5_pulse_err_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_pulse_o |-> $stable(prot_err_o));

  // R10: error only rises after a store
  a_r10_err_needs_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prot_err_o) |-> $past(st_valid_i));

  // R7: error only falls after a clearing store
  a_r7_err_clear_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prot_err_o) |-> $past(st_valid_i && st_addr_i == FLAG_ADDR && !st_data_i[0]));
endmodule

bind prot_reg_guard prot_reg_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_ADDR(PROT_ADDR), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .st_valid_i (st_valid_i),
  .st_addr_i  (st_addr_i),
  .st_data_i  (st_data_i),
  .prot_q_o   (prot_q_o),
  .prot_err_o (prot_err_o),
  .upd_pulse_o(upd_pulse_o)
);

// File: tb/prot_reg_guard_bench.sv
module prot_reg_guard_bench;
  localparam logic [7:0] CMD  = 8'h10;
  localparam logic [7:0] PROT = 8'h11;
  localparam logic [7:0] FLAG = 8'h12;
  localparam logic [7:0] KEY  = 8'hA5;

  typedef struct {
    logic [7:0] q;
    logic       err;
    logic       pul;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       st_valid = 1'b0;
  logic [7:0] st_addr = '0;
  logic [7:0] st_data = '0;
  logic [7:0] prot_q;
  logic       prot_err, upd_pulse;

  int total = 0;
  int bad = 0;
  bit done = 0;
  exp_t sb[$];

  // reference model state: 0 idle, 1 armed, 2 image taken
  int         m_st = 0;
  logic [7:0] m_img = '0;
  logic [7:0] m_q = '0;
  logic       m_err = 1'b0;

  always #5 clk = ~clk;

  prot_reg_guard u_prot_reg_guard (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .st_valid_i (st_valid),
    .st_addr_i  (st_addr),
    .st_data_i  (st_data),
    .prot_q_o   (prot_q),
    .prot_err_o (prot_err),
    .upd_pulse_o(upd_pulse)
  );

  task automatic check(string tag, logic [7:0] q, logic err, logic pul);
    total++;
    if (prot_q !== q || prot_err !== err || upd_pulse !== pul) begin
      bad++;
      $display("FAIL %s: got q=%h err=%b pulse=%b, expected q=%h err=%b pulse=%b",
               tag, prot_q, prot_err, upd_pulse, q, err, pul);
    end
  endtask

  task automatic push(string tag, logic pul);
    exp_t e;
    e.q = m_q; e.err = m_err; e.pul = pul; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic store(logic [7:0] a, logic [7:0] d, string tag);
    logic pul;
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    pul = 1'b0;
    case (m_st)
      0: begin
        if (a == CMD && d == KEY) m_st = 1;
        else if (a == FLAG && !d[0]) m_err = 1'b0;
      end
      1: begin
        if (a == PROT) begin m_img = d; m_st = 2; end
        else begin m_err = 1'b1; m_st = 0; end
      end
      default: begin
        if (a == PROT && d == ~m_img) begin m_q = d; pul = 1'b1; end
        else m_err = 1'b1;
        m_st = 0;
      end
    endcase
    push(tag, pul);
    @(posedge clk);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    st_valid = 1'b0; st_addr = 8'h00; st_data = 8'h00;
    push(tag, 1'b0);
    @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    st_valid = 1'b0;
    rst_n = 1'b0;
    m_st = 0; m_q = '0; m_err = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset state", 8'h00, 1'b0, 1'b0);
    rst_n = 1'b1;
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, e.q, e.err, e.pul);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2 / R8: wrong key and unarmed protected store are ignored
    store(CMD, 8'h5A, "R2 wrong key");
    store(PROT, 8'h3C, "R8 unarmed prot store");
    store(8'h40, 8'hFF, "R8 unrelated store");
    // R6: clean update
    store(CMD, KEY, "R2 arm");
    store(PROT, 8'hC3, "R3 image");
    store(PROT, 8'h3C, "R6 commit");
    idle("R6 pulse low after one cycle");
    // R10: gaps inside the sequence
    store(CMD, KEY, "R10 arm");
    idle("R10 gap");
    store(PROT, 8'h0F, "R10 image");
    idle("R10 gap");
    idle("R10 gap");
    store(PROT, 8'hF0, "R10 commit");
    // R9: no re-use of finished sequence
    store(PROT, 8'h55, "R9 stale image");
    store(PROT, 8'hAA, "R9 stale commit");
    // R3: stray address after arming
    store(CMD, KEY, "R3 arm");
    store(8'h20, 8'h00, "R3 stray address");
    store(PROT, 8'h0F, "R9 after error");
    store(PROT, 8'hF0, "R9 after error");
    // R7: flag clear
    store(FLAG, 8'h01, "R7 bit0 set keeps flag");
    store(FLAG, 8'h00, "R7 clear");
    // R3: flag address after arming is a violation
    store(CMD, KEY, "R3 arm");
    store(FLAG, 8'h00, "R3 flag addr while armed");
    store(FLAG, 8'hFE, "R7 clear");
    // R4: wrong address for final store
    store(CMD, KEY, "R4 arm");
    store(PROT, 8'h55, "R4 image");
    store(CMD, 8'hAA, "R4 stray final");
    store(FLAG, 8'h00, "R7 clear");
    // R5: data mismatch
    store(CMD, KEY, "R5 arm");
    store(PROT, 8'h55, "R5 image");
    store(PROT, 8'hAB, "R5 mismatch");
    idle("R5 hold");
    // R6: back to back success after mismatch
    store(CMD, KEY, "R6 arm");
    store(PROT, 8'h7E, "R6 image");
    store(PROT, 8'h81, "R6 commit");
    store(FLAG, 8'h00, "R7 clear");
    store(CMD, KEY, "R6 arm");
    store(PROT, 8'hFF, "R6 image");
    store(PROT, 8'h00, "R6 commit zero");
    // R1: reset clears flag and register
    store(CMD, KEY, "R3 arm");
    store(CMD, KEY, "R3 double arm");
    idle("R3 flag set");
    wait (sb.size() == 0);
    do_reset();
    idle("R1 after reset");
    wait (sb.size() == 0);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule